// File: doc/BRIEF.md
# Bridge I/O Forwarding Window Decoder

This block keeps the lower and upper bounds of a bridge's I/O forwarding window and classifies each I/O request against that window. Software programs the bounds through a byte-wide configuration port, with one byte for the lower bound and one for the upper bound. A granularity input selects the window step. In coarse mode the window moves in 4 KB steps. In fine mode it moves in 1 KB steps, and two extra bits of each bound become writable.

Each request carries a 16-bit I/O address and a direction tag. One clock after the request is accepted, the block reports one of two results. A request heading toward the secondary bus is forwarded when its address is inside the window and I/O space decoding is enabled. A request arriving from the secondary side with an address outside the window is marked for master abort.

Top module: `iowin_decoder`

## Requirements
- R1: After reset, both bound bytes read as 00h and `rsp_valid`, `rsp_fwd` and `rsp_mabort` are 0.
- R2: Bits 7:4 of a bound byte are always writable. They hold I/O address bits 15:12 of that bound.
- R3: Bits 1:0 of a bound byte always read 0, and writes to them have no effect.
- R4: When `fine_en` is 1, bits 3:2 of a bound byte are writable and read back as written. When `fine_en` is 0, they read as 0 and writes to them are ignored. The stored value is kept and reappears once `fine_en` returns to 1.
- R5: The lower bound is {base[7:4], fine_en ? base[3:2] : 00b, ten zero bits}. The upper bound is {limit[7:4], fine_en ? limit[3:2] : 11b, ten one bits}. An address is inside the window when lower ≤ address ≤ upper.
- R6: For a request with `req_dir`=1 (toward the secondary bus), `rsp_fwd` is 1 exactly when the address is inside the window and `io_en` is 1. `rsp_mabort` is 0.
- R7: For a request with `req_dir`=0 (from the secondary side), `rsp_fwd` is 0 and `rsp_mabort` is 1 exactly when the address is outside the window.
- R8: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. The request is judged on the bounds, `fine_en` and `io_en` as they were at the accepting edge, so a configuration write in the same cycle affects only later requests.
- R9: `cfg_sel`=0 addresses the lower bound and `cfg_sel`=1 addresses the upper bound. `cfg_rdata` shows the selected byte combinationally.
- R10: When the lower bound is above the upper bound, no address is inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fine_en | input | 1 | 1 KB granularity mode |
| io_en | input | 1 | I/O space decode enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = lower bound, 1 = upper bound |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Selected bound byte |
| req_valid | input | 1 | Request accepted this cycle |
| req_addr | input | 16 | I/O address of request |
| req_dir | input | 1 | 1 = toward secondary, 0 = from secondary |
| rsp_valid | output | 1 | Result valid |
| rsp_fwd | output | 1 | Forward the request |
| rsp_mabort | output | 1 | Terminate with master abort |

## Verification
The bench builds the block with its default widths: a 16-bit address, a 4-bit coarse field, a 2-bit fine field and 2 hardwired capability bits. With these widths the bench can sweep the whole 64 KB I/O space, probing both ends of every 256-byte slot in both directions. That sweep covers each 1 KB and 4 KB window edge in both granularity modes. It also covers the empty-window case, the retention of fine bits while fine mode is off, and a configuration write that collides with a request.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
   typedef enum logic {
      SEL_LOWER = 1'b0,
      SEL_UPPER = 1'b1
   } iowin_sel_e;

   typedef enum logic {
      DIR_FROM_SEC = 1'b0,
      DIR_TO_SEC   = 1'b1
   } iowin_dir_e;
endpackage

// File: rtl/iowin_bound.sv
module iowin_bound #(
   parameter int  HI_W     = 4,
   parameter int  FINE_W   = 2,
   parameter int  CAP_W    = 2,
   parameter bit  IS_UPPER = 1'b0,
   localparam int CFG_W    = HI_W + FINE_W + CAP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              fine_en,
   input  logic [CFG_W-1:0]  wdata,
   output logic [CFG_W-1:0]  rdata,
   output logic [HI_W-1:0]   coarse,
   output logic [FINE_W-1:0] fine_eff
);
   logic [HI_W-1:0]   hi_q;
   logic [FINE_W-1:0] fine_q;
   logic [FINE_W-1:0] fill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         fine_q <= '0;
      end else if (wr_en) begin
         hi_q <= wdata[CFG_W-1 -: HI_W];
         if (fine_en) fine_q <= wdata[CAP_W +: FINE_W];
      end
   end

   generate
      if (IS_UPPER) begin : g_upper
         assign fill = '1;
      end else begin : g_lower
         assign fill = '0;
      end
   endgenerate

   assign coarse   = hi_q;
   assign fine_eff = fine_en ? fine_q : fill;
   assign rdata    = {hi_q, (fine_en ? fine_q : {FINE_W{1'b0}}), {CAP_W{1'b0}}};

   // R4: fine field locked while granularity is coarse
   a_r4_fine_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !fine_en) |=> $stable(fine_q));

   // R2: coarse field always takes the written byte
   a_r2_coarse_written: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (hi_q == $past(wdata[CFG_W-1 -: HI_W])));
endmodule

// File: rtl/iowin_cmp.sv
module iowin_cmp #(
   parameter int  ADDR_W = 16,
   parameter int  HI_W   = 4,
   parameter int  FINE_W = 2,
   localparam int LOW_W  = ADDR_W - HI_W - FINE_W
) (
   input  logic [HI_W-1:0]   lo_coarse,
   input  logic [FINE_W-1:0] lo_fine,
   input  logic [HI_W-1:0]   up_coarse,
   input  logic [FINE_W-1:0] up_fine,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic [ADDR_W-1:0] lo_addr;
   logic [ADDR_W-1:0] up_addr;

   assign lo_addr = {lo_coarse, lo_fine, {LOW_W{1'b0}}};
   assign up_addr = {up_coarse, up_fine, {LOW_W{1'b1}}};
   assign hit     = (addr >= lo_addr) && (addr <= up_addr);
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
   import iowin_pkg::*;
#(
   parameter int  ADDR_W = 16,
   parameter int  HI_W   = 4,
   parameter int  FINE_W = 2,
   parameter int  CAP_W  = 2,
   localparam int CFG_W  = HI_W + FINE_W + CAP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fine_en,
   input  logic              io_en,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_dir,
   output logic              rsp_valid,
   output logic              rsp_fwd,
   output logic              rsp_mabort
);
   generate
      if (HI_W + FINE_W >= ADDR_W) begin : g_bad_split
         $error("iowin_decoder: bound fields must leave low address bits");
      end
      if (HI_W < 1 || FINE_W < 1 || CAP_W < 0) begin : g_bad_field
         $error("iowin_decoder: illegal field widths");
      end
   endgenerate

   logic [CFG_W-1:0]  rd_w     [2];
   logic [HI_W-1:0]   coarse_w [2];
   logic [FINE_W-1:0] fine_w   [2];
   logic              hit;

   for (genvar gi = 0; gi < 2; gi++) begin : g_bound
      iowin_bound #(
         .HI_W    (HI_W),
         .FINE_W  (FINE_W),
         .CAP_W   (CAP_W),
         .IS_UPPER(gi == 1)
      ) u_bound (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_we && (cfg_sel == 1'(gi))),
         .fine_en (fine_en),
         .wdata   (cfg_wdata),
         .rdata   (rd_w[gi]),
         .coarse  (coarse_w[gi]),
         .fine_eff(fine_w[gi])
      );
   end

   assign cfg_rdata = rd_w[cfg_sel];

   iowin_cmp #(
      .ADDR_W(ADDR_W),
      .HI_W  (HI_W),
      .FINE_W(FINE_W)
   ) u_cmp (
      .lo_coarse(coarse_w[SEL_LOWER]),
      .lo_fine  (fine_w[SEL_LOWER]),
      .up_coarse(coarse_w[SEL_UPPER]),
      .up_fine  (fine_w[SEL_UPPER]),
      .addr     (req_addr),
      .hit      (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_fwd    <= 1'b0;
         rsp_mabort <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_fwd    <= req_valid && (req_dir == DIR_TO_SEC) && hit && io_en;
         rsp_mabort <= req_valid && (req_dir == DIR_FROM_SEC) && !hit;
      end
   end

   // R8: one result per accepted request, one cycle later
   a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(rsp_valid || rsp_fwd || rsp_mabort));
   // R6: no forwarding while I/O decode is off
   a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !io_en) |=> !rsp_fwd);
   // R6: downstream requests never abort
   a_r6_down_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_dir) |=> !rsp_mabort);
   // R7: requests from the secondary side are never forwarded
   a_r7_up_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_dir) |=> !rsp_fwd);
   // R6 and R7: the two verdicts are exclusive
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_fwd && rsp_mabort));
endmodule

// File: tb/iowin_decoder_tb.sv
module iowin_decoder_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fine_en = 1'b0;
   logic        io_en = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic        req_dir = 1'b0;
   logic        rsp_valid, rsp_fwd, rsp_mabort;

   int checks = 0;
   int errors = 0;

   logic [3:0] m_lo_hi = '0, m_up_hi = '0;
   logic [1:0] m_lo_fine = '0, m_up_fine = '0;

   logic [1:0]  exp_q  [$];
   string       tag_q  [$];
   logic [15:0] addr_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   iowin_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .fine_en(fine_en), .io_en(io_en),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_valid(req_valid), .req_addr(req_addr), .req_dir(req_dir),
      .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd), .rsp_mabort(rsp_mabort)
   );

   function automatic logic in_window(logic [15:0] a);
      logic [15:0] lo, up;
      lo = {m_lo_hi, (fine_en ? m_lo_fine : 2'b00), 10'h000};
      up = {m_up_hi, (fine_en ? m_up_fine : 2'b11), 10'h3FF};
      return (a >= lo) && (a <= up);
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // driver: issues a request and records the expected verdict
   task automatic issue(logic [15:0] a, logic d, string tag);
      logic w;
      @(negedge clk);
      cfg_we = 1'b0;
      req_valid = 1'b1; req_addr = a; req_dir = d;
      w = in_window(a);
      exp_q.push_back(d ? {w && io_en, 1'b0} : {1'b0, !w});
      tag_q.push_back(tag);
      addr_q.push_back(a);
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         req_valid = 1'b0; cfg_we = 1'b0;
      end
   endtask

   task automatic wr(logic sel, logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b0;
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel) begin m_up_hi = d[7:4]; if (fine_en) m_up_fine = d[3:2]; end
      else     begin m_lo_hi = d[7:4]; if (fine_en) m_lo_fine = d[3:2]; end
   endtask

   task automatic rd(logic sel, logic [7:0] exp, string tag);
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0; cfg_sel = sel;
      #1;
      check(tag, {8'h00, cfg_rdata}, {8'h00, exp}, "cfg_rdata");
   endtask

   task automatic sweep(string tag);
      for (int s = 0; s < 256; s++) begin
         issue(16'(s * 256), 1'b1, tag);
         issue(16'(s * 256 + 255), 1'b0, tag);
         issue(16'(s * 256 + 255), 1'b1, tag);
         issue(16'(s * 256), 1'b0, tag);
      end
      idle(3);
   endtask

   // monitor: pops and compares results as they appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8 unexpected result actual=1 expected=0");
         end else begin
            logic [1:0] e;
            string t;
            logic [15:0] a;
            e = exp_q.pop_front(); t = tag_q.pop_front(); a = addr_q.pop_front();
            checks++;
            if ({rsp_fwd, rsp_mabort} !== e) begin
               errors++;
               $display("FAIL %s addr=%h fwd/mabort actual=%b expected=%b",
                        t, a, {rsp_fwd, rsp_mabort}, e);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      // R1: reset state
      @(negedge clk);
      cfg_sel = 1'b0; #1 check("R1", {8'h0, cfg_rdata}, 16'h0, "lower byte in reset");
      cfg_sel = 1'b1; #1 check("R1", {8'h0, cfg_rdata}, 16'h0, "upper byte in reset");
      check("R1", {13'h0, rsp_valid, rsp_fwd, rsp_mabort}, 16'h0, "outputs in reset");
      rst_n = 1'b1;
      io_en = 1'b1;
      idle(2);

      // R5: default window 0000..0FFF
      issue(16'h0FFF, 1'b1, "R5");
      issue(16'h1000, 1'b1, "R5");
      issue(16'h1000, 1'b0, "R7");
      idle(3);

      // R2 R3 R4 R9: coarse mode writes
      wr(1'b0, 8'hAF);
      rd(1'b0, 8'hA0, "R3");
      wr(1'b1, 8'hD7);
      rd(1'b1, 8'hD0, "R4");
      rd(1'b0, 8'hA0, "R9");
      sweep("R5");
      io_en = 1'b0;
      issue(16'hB000, 1'b1, "R6");
      issue(16'h0000, 1'b0, "R7");
      idle(3);
      io_en = 1'b1;

      // R4: fine mode, ignored bits were not stored
      fine_en = 1'b1;
      rd(1'b0, 8'hA0, "R4");
      wr(1'b0, 8'hAB);
      rd(1'b0, 8'hA8, "R3");
      wr(1'b1, 8'hD4);
      rd(1'b1, 8'hD4, "R4");
      sweep("R5");
      issue(16'hA7FF, 1'b1, "R6");
      issue(16'hA800, 1'b1, "R6");
      issue(16'hD7FF, 1'b0, "R7");
      issue(16'hD800, 1'b0, "R7");
      idle(3);

      // R4: coarse mode masks, retains stored fine bits
      fine_en = 1'b0;
      rd(1'b0, 8'hA0, "R4");
      wr(1'b1, 8'hDC);
      rd(1'b1, 8'hD0, "R4");
      issue(16'hA000, 1'b1, "R5");
      issue(16'hDFFF, 1'b1, "R5");
      idle(3);
      fine_en = 1'b1;
      rd(1'b0, 8'hA8, "R4");
      rd(1'b1, 8'hD4, "R4");

      // R10: empty window
      fine_en = 1'b0;
      wr(1'b0, 8'hC0);
      wr(1'b1, 8'h30);
      sweep("R10");

      // R8: write in the same cycle as a request sees old bounds
      wr(1'b0, 8'h20);
      wr(1'b1, 8'h50);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h30;
      req_valid = 1'b1; req_addr = 16'h4800; req_dir = 1'b1;
      exp_q.push_back({in_window(16'h4800) && io_en, 1'b0});
      tag_q.push_back("R8"); addr_q.push_back(16'h4800);
      @(negedge clk);
      cfg_we = 1'b0;
      m_up_hi = 4'h3;
      req_addr = 16'h4800; req_dir = 1'b1;
      exp_q.push_back({in_window(16'h4800) && io_en, 1'b0});
      tag_q.push_back("R8"); addr_q.push_back(16'h4800);
      idle(4);

      // R8: nothing outstanding, output idle
      check("R8", 16'(exp_q.size()), 16'h0, "pending results");
      check("R8", {15'h0, rsp_valid}, 16'h0, "rsp_valid when idle");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule